// File: doc/BRIEF.md
# GPIO Bank Controller with Edge and Level Interrupts

This block manages one bank of general-purpose pins from a simple 32-bit register bus. Software sets each pin's direction and output value, reads the sampled pin levels, and programs interrupt triggers for the lowest eight pins. Direction, output data and interrupt control are never written as whole words. Each one has a pair of addresses: a 1 written to the first address sets the matching bits, and a 1 written to the second address clears them. Bits written as 0 are left unchanged.

Every pin input passes through a two-stage synchroniser. For the interrupt-capable pins, an optional debounce filter can follow the synchroniser. The filtered level drives an edge or level detector. Detected events set latched status bits, software clears them by writing ones, and one interrupt line goes high while any status bit is set. A read returns its data on the cycle after the read strobe.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is all ones (every pin is an output), `pin_out` is 0 and `irq` is 0.
- R2: The direction register (read at 0x00) holds a 1 for each input pin. A 1 written to 0x08 sets that bit, and a 1 written to 0x04 clears it. Bits written as 0 do not change. `pin_oe` is the inverse of the direction register.
- R3: A 1 written to 0x10 sets that bit of the output latch, and a 1 written to 0x14 clears it. Bits written as 0 do not change. A read of 0x10 returns the latch, and `pin_out` drives it.
- R4: A read of 0x0C returns `pin_in` after a two-flop synchroniser. A pin change made just before clock edge k appears in a read whose strobe is sampled at edge k+2 or later.
- R5: The interrupt control word changes only through 0x18 (write-one-to-set) and 0x1C (write-one-to-clear), and a read of 0x18 returns it. Its fields, with n as the pin number, are: bit n rise/high enable, bit 8+n fall/low enable, bit 16+n debounce enable, bit 24+n level mode.
- R6: With level mode at 0, the rise enable latches status on a rising edge and the fall enable latches status on a falling edge. With both enables set, either edge latches status. An edge of the opposite direction is ignored.
- R7: With level mode at 1, the rise enable makes a high level active and the fall enable makes a low level active. The status bit follows the active level. After a clear, it sets again while the level stays active.
- R8: Only pins 0 to 7 raise interrupts. A read of the status register at 0x24 always returns 0 in bits 31:8.
- R9: A 1 written to bit n of 0x20 clears the latched edge status of pin n. A pin whose rise and fall enables are both 0 never sets its status.
- R10: `irq` is high exactly when at least one status bit is set.
- R11: When a pin's debounce enable is set, a new input level is accepted only after it has been stable at the synchroniser output for DB_CYCLES consecutive cycles (default 4). Without debounce, a one-cycle pulse is detected.
- R12: Read data appears on the cycle after the read strobe and reflects any write completed on an earlier cycle. Addresses that have no readable register return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output latch value |
| pin_oe | output | NPINS | Output enable, high for an output pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench reads the pin-value register on three successive cycles after a pin change. A design with the wrong number of synchroniser stages would show the new value on the wrong read. A level-mode pin is cleared while its level is still active: a design that made level status sticky would keep the bit after the level goes away, and one that ignored the level would stay clear after the write. A two-cycle glitch on a debounced pin must raise nothing, while a one-cycle pulse on an undebounced pin must latch. A counter that accepted too early, or a filter that was always on, would fail one of these two checks. Toggling pins above 7 with every enable set catches status bits that leak above bit 7. An edge in the direction that is not enabled must set no status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [5:0] {
    A_DIR     = 6'h00,
    A_DIR_OUT = 6'h04,
    A_DIR_IN  = 6'h08,
    A_VAL     = 6'h0C,
    A_OSET    = 6'h10,
    A_OCLR    = 6'h14,
    A_ICSET   = 6'h18,
    A_ICCLR   = 6'h1C,
    A_ICLR    = 6'h20,
    A_ISTAT   = 6'h24
  } reg_addr_e;

  // Bit offset of each byte-wide field in the interrupt control word.
  localparam int unsigned F_RISE = 0;
  localparam int unsigned F_FALL = 8;
  localparam int unsigned F_DB   = 16;
  localparam int unsigned F_LVL  = 24;

  // Write-one-to-set update.
  function automatic logic [31:0] w1s(input logic [31:0] old, input logic [31:0] mask);
    return old | mask;
  endfunction

  // Write-one-to-clear update.
  function automatic logic [31:0] w1c(input logic [31:0] old, input logic [31:0] mask);
    return old & ~mask;
  endfunction

  // Trigger condition for one pin: level mode uses the enables as polarity
  // selects, edge mode compares the current level against the previous one.
  function automatic logic trig_hit(input logic rise_en, input logic fall_en,
                                    input logic lvl, input logic cur, input logic prev);
    if (lvl) return (rise_en & cur) | (fall_en & ~cur);
    return (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
  endfunction

  // Debounce counter is about to complete its stable window.
  function automatic logic db_done(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en,
  input  logic [W-1:0] raw,
  output logic [W-1:0] filt
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CW-1:0] cnt;
    logic          f;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        f   <= 1'b0;
      end else if (!en[b]) begin
        f   <= raw[b];
        cnt <= '0;
      end else if (raw[b] == f) begin
        cnt <= '0;
      end else if (db_done(32'(cnt), CYCLES)) begin
        f   <= raw[b];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign filt[b] = f;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] cur,
  input  logic [NIRQ-1:0] rise_en,
  input  logic [NIRQ-1:0] fall_en,
  input  logic [NIRQ-1:0] lvl_mode,
  input  logic [NIRQ-1:0] clr,
  output logic [NIRQ-1:0] set_req,
  output logic [NIRQ-1:0] status
);
  logic [NIRQ-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  for (genvar b = 0; b < NIRQ; b++) begin : g_pin
    assign set_req[b] = trig_hit(rise_en[b], fall_en[b], lvl_mode[b], cur[b], prev[b]);

    always_ff @(posedge clk) begin
      if (!rst_n)           status[b] <= 1'b0;
      else if (lvl_mode[b]) status[b] <= set_req[b] & ~clr[b];
      else                  status[b] <= (status[b] & ~clr[b]) | set_req[b];
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned NIRQ        = 8,
  parameter int unsigned DB_CYCLES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [5:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] out_q;
  logic [31:0]      ictl_q;
  logic [NPINS-1:0] pin_sync;
  logic [NIRQ-1:0]  pin_filt;
  logic [NIRQ-1:0]  irq_set_req;
  logic [NIRQ-1:0]  irq_status;
  logic [NIRQ-1:0]  irq_clr;
  logic [31:0]      rd_mux;

  function automatic logic hit(input logic [5:0] a, input reg_addr_e r);
    return reg_wr && (a == r);
  endfunction

  // Register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ictl_q <= '0;
    end else begin
      if (hit(reg_addr, A_DIR_IN))
        dir_q <= NPINS'(w1s(32'(dir_q), reg_wdata));
      else if (hit(reg_addr, A_DIR_OUT))
        dir_q <= NPINS'(w1c(32'(dir_q), reg_wdata));
      if (hit(reg_addr, A_OSET))
        out_q <= NPINS'(w1s(32'(out_q), reg_wdata));
      else if (hit(reg_addr, A_OCLR))
        out_q <= NPINS'(w1c(32'(out_q), reg_wdata));
      if (hit(reg_addr, A_ICSET))
        ictl_q <= w1s(ictl_q, reg_wdata);
      else if (hit(reg_addr, A_ICCLR))
        ictl_q <= w1c(ictl_q, reg_wdata);
    end
  end

  assign irq_clr = hit(reg_addr, A_ICLR) ? reg_wdata[NIRQ-1:0] : '0;

  // Input path
  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_in),
    .q (pin_sync)
  );

  gpio_debounce #(.W(NIRQ), .CYCLES(DB_CYCLES)) i_deb (
    .clk (clk),
    .rst_n (rst_n),
    .en (ictl_q[F_DB +: NIRQ]),
    .raw (pin_sync[NIRQ-1:0]),
    .filt (pin_filt)
  );

  gpio_irq_unit #(.NIRQ(NIRQ)) i_irq (
    .clk (clk),
    .rst_n (rst_n),
    .cur (pin_filt),
    .rise_en (ictl_q[F_RISE +: NIRQ]),
    .fall_en (ictl_q[F_FALL +: NIRQ]),
    .lvl_mode (ictl_q[F_LVL +: NIRQ]),
    .clr (irq_clr),
    .set_req (irq_set_req),
    .status (irq_status)
  );

  // Read path
  always_comb begin
    case (reg_addr)
      A_DIR:   rd_mux = 32'(dir_q);
      A_VAL:   rd_mux = 32'(pin_sync);
      A_OSET:  rd_mux = 32'(out_q);
      A_ICSET: rd_mux = ictl_q;
      A_ISTAT: rd_mux = 32'(irq_status);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq     = |irq_status;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned NIRQ  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [5:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [31:0]      ictl,
  input logic [NIRQ-1:0]  set_req
);
  p_dir_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DIR_IN) |=>
      ((~pin_oe & $past(reg_wdata[NPINS-1:0])) == '0 ? $past(reg_wdata[NPINS-1:0]) == '0 : 1'b1)
      && ((pin_oe & $past(reg_wdata[NPINS-1:0])) == '0));

  p_dir_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DIR_OUT) |=>
      ((pin_oe & $past(reg_wdata[NPINS-1:0])) == $past(reg_wdata[NPINS-1:0])));

  p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_OSET) |=>
      ((pin_out & $past(reg_wdata[NPINS-1:0])) == $past(reg_wdata[NPINS-1:0])));

  p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_OCLR) |=>
      ((pin_out & $past(reg_wdata[NPINS-1:0])) == '0));

  p_stat_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_ISTAT) |=> (reg_rdata[31:NIRQ] == '0));

  p_masked_pin_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req & ~(ictl[F_RISE +: NIRQ] | ictl[F_FALL +: NIRQ])) == '0);

  p_irq_needs_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|set_req));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd && rst_n && $past(rst_n)) |=> $stable(reg_rdata));
endmodule

bind gpio_bank_ctrl gpio_bank_checker #(.NPINS(NPINS), .NIRQ(NIRQ)) i_chk (
  .clk (clk),
  .rst_n (rst_n),
  .reg_wr (reg_wr),
  .reg_rd (reg_rd),
  .reg_addr (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_out (pin_out),
  .pin_oe (pin_oe),
  .irq (irq),
  .ictl (ictl_q),
  .set_req (irq_set_req)
);

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk (clk), .rst_n (rst_n),
    .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rdr(input logic [5:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanup();
    wr(6'h1C, 32'hFFFF_FFFF);
    pin_in = '0;
    wait_cyc(6);
    wr(6'h20, 32'hFF);
    wait_cyc(2);
  endtask

  task automatic t_reset();
    rdr(6'h00, rd); chk("R1 dir", rd, 0);
    rdr(6'h10, rd); chk("R1 out latch", rd, 0);
    rdr(6'h18, rd); chk("R1 ctrl", rd, 0);
    rdr(6'h24, rd); chk("R1 status", rd, 0);
    chk("R1 pin_oe", pin_oe, 32'hFFFF_FFFF);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rdr(6'h28, rd); chk("R12 unmapped read", rd, 0);
  endtask

  task automatic t_direction();
    wr(6'h08, 32'h0000_00F0);
    rdr(6'h00, rd); chk("R2 set input", rd, 32'h0000_00F0);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_FF0F);
    wr(6'h08, 32'h0000_0F00);
    rdr(6'h00, rd); chk("R2 zero bits kept", rd, 32'h0000_0FF0);
    wr(6'h04, 32'h0000_0030);
    rdr(6'h00, rd); chk("R2 set output", rd, 32'h0000_0FC0);
    chk("R2 pin_oe after clear", pin_oe, 32'hFFFF_F03F);
    rdr(6'h04, rd); chk("R12 set-only address reads 0", rd, 0);
  endtask

  task automatic t_output();
    wr(6'h10, 32'hA5A5_0000);
    rdr(6'h10, rd); chk("R3 R12 latch set then read", rd, 32'hA5A5_0000);
    chk("R3 pin_out", pin_out, 32'hA5A5_0000);
    wr(6'h14, 32'h8000_0001);
    rdr(6'h10, rd); chk("R3 latch clear", rd, 32'h25A5_0000);
    chk("R3 pin_out after clear", pin_out, 32'h25A5_0000);
  endtask

  task automatic t_value();
    pin_in = 32'h1234_5600;
    wait_cyc(4);
    rdr(6'h0C, rd); chk("R4 pin value", rd, 32'h1234_5600);
    pin_in = 32'hCAFE_0000;
    rdr(6'h0C, rd); chk("R4 sync edge1 old", rd, 32'h1234_5600);
    rdr(6'h0C, rd); chk("R4 sync edge2 old", rd, 32'h1234_5600);
    rdr(6'h0C, rd); chk("R4 sync edge3 new", rd, 32'hCAFE_0000);
    pin_in = '0;
    wait_cyc(6);
  endtask

  task automatic t_ctrl();
    wr(6'h18, 32'hFF00_FF00);
    rdr(6'h18, rd); chk("R5 ctrl set", rd, 32'hFF00_FF00);
    wr(6'h1C, 32'h0F00_0F00);
    rdr(6'h18, rd); chk("R5 ctrl clear", rd, 32'hF000_F000);
    cleanup();
  endtask

  task automatic t_edge_rise();
    wr(6'h18, 32'h0000_0001);
    pin_in[0] = 1'b1; wait_cyc(6);
    rdr(6'h24, rd); chk("R6 rising edge", rd, 32'h1);
    chk("R10 irq on", {31'd0, irq}, 1);
    pin_in[0] = 1'b0; wait_cyc(6);
    rdr(6'h24, rd); chk("R6 edge status sticky", rd, 32'h1);
    wr(6'h20, 32'h1); wait_cyc(2);
    rdr(6'h24, rd); chk("R9 clear", rd, 0);
    chk("R10 irq off", {31'd0, irq}, 0);
    cleanup();
  endtask

  task automatic t_edge_fall();
    wr(6'h18, 32'h0000_0200);
    pin_in[1] = 1'b1; wait_cyc(6);
    rdr(6'h24, rd); chk("R6 rise ignored in fall mode", rd, 0);
    pin_in[1] = 1'b0; wait_cyc(6);
    rdr(6'h24, rd); chk("R6 falling edge", rd, 32'h2);
    cleanup();
  endtask

  task automatic t_edge_both();
    wr(6'h18, 32'h0000_0404);
    pin_in[2] = 1'b1; wait_cyc(6);
    rdr(6'h24, rd); chk("R6 both rise", rd, 32'h4);
    wr(6'h20, 32'h4); wait_cyc(2);
    pin_in[2] = 1'b0; wait_cyc(6);
    rdr(6'h24, rd); chk("R6 both fall", rd, 32'h4);
    cleanup();
  endtask

  task automatic t_level_high();
    wr(6'h18, 32'h0800_0008);
    pin_in[3] = 1'b1; wait_cyc(6);
    rdr(6'h24, rd); chk("R7 level high", rd, 32'h8);
    wr(6'h20, 32'h8); wait_cyc(3);
    rdr(6'h24, rd); chk("R7 reasserts after clear", rd, 32'h8);
    pin_in[3] = 1'b0; wait_cyc(6);
    rdr(6'h24, rd); chk("R7 follows level", rd, 0);
    chk("R10 irq drops with level", {31'd0, irq}, 0);
    cleanup();
  endtask

  task automatic t_level_low();
    wr(6'h18, 32'h1000_1000);
    wait_cyc(6);
    rdr(6'h24, rd); chk("R7 level low active", rd, 32'h10);
    pin_in[4] = 1'b1; wait_cyc(6);
    rdr(6'h24, rd); chk("R7 level low released", rd, 0);
    cleanup();
  endtask

  task automatic t_mask();
    wr(6'h18, 32'h0000_2020);
    wr(6'h1C, 32'h0000_2020);
    pin_in[5] = 1'b1; wait_cyc(6);
    pin_in[5] = 1'b0; wait_cyc(6);
    rdr(6'h24, rd); chk("R9 masked pin", rd, 0);
    chk("R9 masked irq", {31'd0, irq}, 0);
    cleanup();
  endtask

  task automatic t_upper();
    wr(6'h18, 32'h0000_FFFF);
    pin_in = 32'hFFFF_FF00; wait_cyc(6);
    pin_in = 32'h0000_0000; wait_cyc(6);
    rdr(6'h24, rd); chk("R8 upper pins raise nothing", rd, 0);
    pin_in[6] = 1'b1; wait_cyc(6);
    rdr(6'h24, rd); chk("R8 pin6 only", rd, 32'h40);
    cleanup();
  endtask

  task automatic t_debounce();
    wr(6'h18, 32'h0080_0080);
    pin_in[7] = 1'b1; wait_cyc(2);
    pin_in[7] = 1'b0; wait_cyc(10);
    rdr(6'h24, rd); chk("R11 glitch rejected", rd, 0);
    pin_in[7] = 1'b1; wait_cyc(12);
    rdr(6'h24, rd); chk("R11 stable accepted", rd, 32'h80);
    cleanup();
    wr(6'h18, 32'h0000_0001);
    pin_in[0] = 1'b1; wait_cyc(1);
    pin_in[0] = 1'b0; wait_cyc(8);
    rdr(6'h24, rd); chk("R11 no debounce pulse seen", rd, 32'h1);
    cleanup();
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_output();
    t_value();
    t_ctrl();
    t_edge_rise();
    t_edge_fall();
    t_edge_both();
    t_level_high();
    t_level_low();
    t_mask();
    t_upper();
    t_debounce();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule